// File: doc/BRIEF.md
# CAN Bit Timing Quantum Generator

This block divides the peripheral clock into time quanta and builds each CAN bit from three consecutive segments: a single synchronization quantum, a first phase segment that ends at the sample point, and a second phase segment that closes the bit. It outputs a strobe on every quantum. It also outputs a sample strobe on the last clock of the first phase segment and a transmit strobe on the first clock of every bit. The receive path feeds the block a recessive-to-dominant edge pulse. The block uses that pulse to move the bit boundary, lengthening the first segment or shortening the second by no more than the jump width. A separate hard-synchronization pulse restarts the bit outright.

The block holds two parameter sets: one for arbitration (nominal) and one for the faster data phase of bit-rate-switched FD frames. A phase-select input picks between them. The choice is captured at a sample point and applied from the next bit onward, so a single bit never mixes the two sets. Each set has its own legal ranges. Both sets are checked continuously, and while any field is out of range an error flag stays high and the block produces no timing at all. Settings are loaded through a load strobe and only while the block is stopped.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, with no load, each set has jump width 4, first segment 11, second segment 4 and prescaler 1. The bit is therefore 16 quanta long, and the sample strobe comes 11 clocks after the transmit strobe.
- R2: A quantum lasts `pre` clocks. The bit lasts `pre*(1+seg1+seg2)` clocks. The sample strobe falls `pre*(1+seg1)-1` clocks after the transmit strobe, which is asserted for one clock at the start of the synchronization segment.
- R3: The nominal set is legal only if all of these hold: jump width 1..128, seg1 2..256, seg2 2..128, total quanta 5..385, prescaler 1..512. Otherwise `cfg_err` is 1.
- R4: The data set is legal only if all of these hold: jump width 1..16, seg1 1..32, seg2 1..16, total quanta 3..49, prescaler 1..32. Otherwise `cfg_err` is 1.
- R5: While `run` is 0, or while `cfg_err` is 1, no strobe and no quantum tick occur. The first transmit strobe appears in the first clock in which `run` is 1 and the settings are legal.
- R6: `cfg_ld` loads both sets only while `run` is 0. A load attempted while `run` is 1 has no effect.
- R7: An edge in quantum c of the first segment lengthens that segment by min(c, jump width) quanta.
- R8: An edge in quantum c of the second segment shortens that segment by min(seg2-c, jump width) quanta.
- R9: At most one edge per bit is acted on. An edge during the synchronization quantum is ignored and does not use up that one resynchronization.
- R10: A hard-sync pulse in clock H restarts the bit. The transmit strobe appears at H+1, and the jump width does not limit it.
- R11: `phase_sel` (1 = data set) is captured only at a sample strobe and takes effect at the next bit start. `cur_phase` reports the set in use. Each bit starts on the nominal set after `run` rises.
- R12: Every sample strobe falls in a clock where `tq_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Enables bit timing |
| cfg_ld | input | 1 | Loads both timing sets while stopped |
| nom_pre | input | 10 | Nominal prescaler, clocks per quantum |
| nom_seg1 | input | 9 | Nominal first phase segment, quanta |
| nom_seg2 | input | 8 | Nominal second phase segment, quanta |
| nom_sjw | input | 8 | Nominal jump width, quanta |
| dat_pre | input | 10 | Data prescaler |
| dat_seg1 | input | 9 | Data first phase segment |
| dat_seg2 | input | 8 | Data second phase segment |
| dat_sjw | input | 8 | Data jump width |
| phase_sel | input | 1 | 0 = nominal, 1 = data for following bits |
| rx_edge | input | 1 | Recessive-to-dominant edge seen on receive |
| hard_sync | input | 1 | Restart the bit at the synchronization segment |
| tq_tick | output | 1 | Last clock of each quantum |
| sample_pt | output | 1 | Sample point strobe |
| tx_pt | output | 1 | Bit start strobe |
| cur_phase | output | 1 | Set in use, 1 = data |
| cfg_err | output | 1 | Some stored setting is out of range |

## Verification
On every cycle the assertions check four things. The jump-width corrections never exceed the active jump width. The error flag and the stored sets stay fixed while running. The prescaler count stays below the active prescaler. The captured and active set selections change only at a sample strobe and at a bit start, respectively. Only the bench scenarios can show the absolute placement of the strobes: bit lengths under the defaults, under a prescaler and under the data set. The same holds for the exact lengthening and shortening after edges, the recovery after a hard sync, the rejection of a load while running, and the acceptance or rejection of each range boundary.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PW = 10,
  parameter int S1W = 9,
  parameter int S2W = 8,
  parameter int JW = 8,
  parameter int NOM_PRE_MAX = 512,
  parameter int NOM_S1_MIN = 2,
  parameter int NOM_S1_MAX = 256,
  parameter int NOM_S2_MIN = 2,
  parameter int NOM_S2_MAX = 128,
  parameter int NOM_SJW_MAX = 128,
  parameter int NOM_TOT_MIN = 5,
  parameter int NOM_TOT_MAX = 385,
  parameter int DAT_PRE_MAX = 32,
  parameter int DAT_S1_MIN = 1,
  parameter int DAT_S1_MAX = 32,
  parameter int DAT_S2_MIN = 1,
  parameter int DAT_S2_MAX = 16,
  parameter int DAT_SJW_MAX = 16,
  parameter int DAT_TOT_MIN = 3,
  parameter int DAT_TOT_MAX = 49,
  parameter int RST_PRE = 1,
  parameter int RST_S1 = 11,
  parameter int RST_S2 = 4,
  parameter int RST_SJW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           cfg_ld,
  input  logic [PW-1:0]  nom_pre,
  input  logic [S1W-1:0] nom_seg1,
  input  logic [S2W-1:0] nom_seg2,
  input  logic [JW-1:0]  nom_sjw,
  input  logic [PW-1:0]  dat_pre,
  input  logic [S1W-1:0] dat_seg1,
  input  logic [S2W-1:0] dat_seg2,
  input  logic [JW-1:0]  dat_sjw,
  input  logic           phase_sel,
  input  logic           rx_edge,
  input  logic           hard_sync,
  output logic           tq_tick,
  output logic           sample_pt,
  output logic           tx_pt,
  output logic           cur_phase,
  output logic           cfg_err
);

  localparam int CW = S1W + 1;
  localparam int TW = CW + 1;

  typedef enum logic [1:0] {ST_SYNC, ST_PH1, ST_PH2} seg_t;

  logic [PW-1:0]  npre_q, dpre_q, pre_c, pc;
  logic [S1W-1:0] ns1_q, ds1_q, s1_c;
  logic [S2W-1:0] ns2_q, ds2_q, s2_c;
  logic [JW-1:0]  nsj_q, dsj_q, sjw_c;
  logic [JW-1:0]  ext, shr, ext_now, shr_now;
  logic [CW-1:0]  cnt, len1, err2;
  seg_t           st;
  logic           rs_done, cur_set, nxt_set;
  logic           run_ok, tq, edge_ok, leave1, leave2;

  function automatic logic set_bad(
    input logic [PW-1:0] p, input logic [S1W-1:0] a, input logic [S2W-1:0] b,
    input logic [JW-1:0] j, input int pmax, input int amin, input int amax,
    input int bmin, input int bmax, input int jmax, input int tmin, input int tmax);
    int tot;
    tot = 1 + int'(a) + int'(b);
    return (p == '0) || (int'(p) > pmax) || (int'(a) < amin) || (int'(a) > amax) ||
           (int'(b) < bmin) || (int'(b) > bmax) || (j == '0) || (int'(j) > jmax) ||
           (tot < tmin) || (tot > tmax);
  endfunction

  function automatic logic [JW-1:0] clip(input logic [CW-1:0] e, input logic [JW-1:0] j);
    if (e > CW'(j)) return j;
    return JW'(e);
  endfunction

  assign cfg_err = set_bad(npre_q, ns1_q, ns2_q, nsj_q, NOM_PRE_MAX, NOM_S1_MIN, NOM_S1_MAX,
                           NOM_S2_MIN, NOM_S2_MAX, NOM_SJW_MAX, NOM_TOT_MIN, NOM_TOT_MAX) ||
                   set_bad(dpre_q, ds1_q, ds2_q, dsj_q, DAT_PRE_MAX, DAT_S1_MIN, DAT_S1_MAX,
                           DAT_S2_MIN, DAT_S2_MAX, DAT_SJW_MAX, DAT_TOT_MIN, DAT_TOT_MAX);

  assign pre_c = cur_set ? dpre_q : npre_q;
  assign s1_c  = cur_set ? ds1_q  : ns1_q;
  assign s2_c  = cur_set ? ds2_q  : ns2_q;
  assign sjw_c = cur_set ? dsj_q  : nsj_q;

  assign run_ok  = run && !cfg_err;
  assign tq      = run_ok && (pc == pre_c - PW'(1));
  assign edge_ok = run_ok && rx_edge && !hard_sync && !rs_done;
  assign err2    = CW'(s2_c) - cnt;
  assign ext_now = (edge_ok && st == ST_PH1) ? clip(cnt, sjw_c) : ext;
  assign shr_now = (edge_ok && st == ST_PH2) ? clip(err2, sjw_c) : shr;
  assign len1    = CW'(s1_c) + CW'(ext_now);
  assign leave1  = tq && st == ST_PH1 && cnt == len1;
  assign leave2  = tq && st == ST_PH2 && (TW'(cnt) + TW'(shr_now) >= TW'(s2_c));

  assign tq_tick   = tq;
  assign sample_pt = leave1;
  assign tx_pt     = run_ok && st == ST_SYNC && pc == '0;
  assign cur_phase = cur_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npre_q <= PW'(RST_PRE);  dpre_q <= PW'(RST_PRE);
      ns1_q  <= S1W'(RST_S1);  ds1_q  <= S1W'(RST_S1);
      ns2_q  <= S2W'(RST_S2);  ds2_q  <= S2W'(RST_S2);
      nsj_q  <= JW'(RST_SJW);  dsj_q  <= JW'(RST_SJW);
    end else if (cfg_ld && !run) begin
      npre_q <= nom_pre;  dpre_q <= dat_pre;
      ns1_q  <= nom_seg1; ds1_q  <= dat_seg1;
      ns2_q  <= nom_seg2; ds2_q  <= dat_seg2;
      nsj_q  <= nom_sjw;  dsj_q  <= dat_sjw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_SYNC; pc <= '0; cnt <= '0; ext <= '0; shr <= '0;
      rs_done <= 1'b0; cur_set <= 1'b0; nxt_set <= 1'b0;
    end else if (!run_ok) begin
      st <= ST_SYNC; pc <= '0; cnt <= '0; ext <= '0; shr <= '0;
      rs_done <= 1'b0; cur_set <= 1'b0; nxt_set <= 1'b0;
    end else if (hard_sync) begin
      st <= ST_SYNC; pc <= '0; cnt <= '0; ext <= '0; shr <= '0;
      rs_done <= 1'b0;
    end else begin
      ext <= ext_now;
      shr <= shr_now;
      if (edge_ok && st != ST_SYNC) rs_done <= 1'b1;
      pc <= tq ? '0 : pc + PW'(1);
      if (tq) begin
        case (st)
          ST_SYNC: begin
            st <= ST_PH1;
            cnt <= CW'(1);
          end
          ST_PH1: begin
            if (leave1) begin
              st <= ST_PH2;
              cnt <= CW'(1);
              ext <= '0;
              nxt_set <= phase_sel;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_PH2: begin
            if (leave2) begin
              st <= ST_SYNC;
              cnt <= '0;
              shr <= '0;
              rs_done <= 1'b0;
              cur_set <= nxt_set;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: st <= ST_SYNC;
        endcase
      end
    end
  end

  // R7
  ext_in_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok |-> ext <= sjw_c);

  // R8
  shr_in_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok |-> shr <= sjw_c);

  // R6
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> $stable(cfg_err) && $stable(ns1_q) && $stable(ds1_q) && $stable(npre_q));

  // R2
  pc_below_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok |-> pc < pre_c);

  // R11
  set_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok && $past(run_ok) && (cur_set != $past(cur_set)) |-> tx_pt);

  // R11
  pick_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok && $past(run_ok) && (nxt_set != $past(nxt_set)) |-> $past(sample_pt));

  // R9
  one_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_done && $past(rs_done) && st == $past(st) && !$past(hard_sync) |-> $stable(ext) && $stable(shr));

endmodule

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, run = 1'b0, cfg_ld = 1'b0;
  logic [9:0] nom_pre = 10'd1, dat_pre = 10'd1;
  logic [8:0] nom_seg1 = 9'd11, dat_seg1 = 9'd11;
  logic [7:0] nom_seg2 = 8'd4, dat_seg2 = 8'd4;
  logic [7:0] nom_sjw = 8'd4, dat_sjw = 8'd4;
  logic phase_sel = 1'b0, rx_edge = 1'b0, hard_sync = 1'b0;
  logic tq_tick, sample_pt, tx_pt, cur_phase, cfg_err;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_ld(cfg_ld),
    .nom_pre(nom_pre), .nom_seg1(nom_seg1), .nom_seg2(nom_seg2), .nom_sjw(nom_sjw),
    .dat_pre(dat_pre), .dat_seg1(dat_seg1), .dat_seg2(dat_seg2), .dat_sjw(dat_sjw),
    .phase_sel(phase_sel), .rx_edge(rx_edge), .hard_sync(hard_sync),
    .tq_tick(tq_tick), .sample_pt(sample_pt), .tx_pt(tx_pt),
    .cur_phase(cur_phase), .cfg_err(cfg_err));

  int cyc = 0;
  int n_cmp = 0, n_bad = 0, n_str = 0;
  int kq[$];
  int cq[$];
  string rq[$];
  int T;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (tx_pt || sample_pt || tq_tick)) n_str++;
    if (rst_n && sample_pt) check(tq_tick == 1'b1, "R12", tq_tick, 1);
    if (rst_n && (tx_pt || sample_pt) && cq.size() > 0) begin
      check(int'(sample_pt) == kq[0] && cyc == cq[0], rq[0], cyc * 10 + int'(sample_pt),
            cq[0] * 10 + kq[0]);
      void'(kq.pop_front()); void'(cq.pop_front()); void'(rq.pop_front());
    end
  end

  always @(posedge clk) if (cyc == 150000) begin
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic want(input int k, input int c, input string r);
    kq.push_back(k); cq.push_back(c); rq.push_back(r);
  endtask

  task automatic load();
    cfg_ld = 1'b1; tick(1); cfg_ld = 1'b0; tick(1);
  endtask

  task automatic start();
    tick(1); run = 1'b1; T = cyc;
  endtask

  task automatic pulse_edge(input int at);
    while (cyc < at) tick(1);
    rx_edge = 1'b1; tick(1); rx_edge = 1'b0;
  endtask

  task automatic drain(input string r);
    for (int i = 0; i < 400 && cq.size() > 0; i++) tick(1);
    check(cq.size() == 0, r, cq.size(), 0);
    kq.delete(); cq.delete(); rq.delete();
    run = 1'b0; tick(2);
  endtask

  task automatic defaults();
    nom_pre = 10'd1; nom_seg1 = 9'd11; nom_seg2 = 8'd4; nom_sjw = 8'd4;
    dat_pre = 10'd1; dat_seg1 = 9'd11; dat_seg2 = 8'd4; dat_sjw = 8'd4;
    load();
  endtask

  task automatic err_case(input bit exp_err, input string r);
    int s0;
    load();
    check(cfg_err == exp_err, r, cfg_err, exp_err);
    if (exp_err) begin
      s0 = n_str; run = 1'b1; tick(10);
      check(n_str == s0, r, n_str - s0, 0);
      run = 1'b0; tick(1);
    end
    defaults();
  endtask

  initial begin
    int s0;
    tick(3); rst_n = 1'b1; tick(1);
    check(tx_pt == 0 && sample_pt == 0 && tq_tick == 0, "R5", {tx_pt, sample_pt, tq_tick}, 0);
    check(cfg_err == 0 && cur_phase == 0, "R1", {cfg_err, cur_phase}, 0);
    s0 = n_str; tick(20);
    check(n_str == s0, "R5", n_str - s0, 0);

    // R1 reset defaults, no load
    want(0, 0, "R5"); want(1, 11, "R1"); want(0, 16, "R1"); want(1, 27, "R1"); want(0, 32, "R1");
    start(); for (int i = 0; i < 5; i++) cq[i] += T;
    drain("R1");

    // R2 prescaler 3
    nom_pre = 10'd3; load();
    start();
    want(0, T, "R2"); want(1, T + 35, "R2"); want(0, T + 48, "R2"); want(1, T + 83, "R2");
    drain("R2");
    defaults();

    // R6 load while running ignored
    start();
    want(0, T, "R6"); want(1, T + 11, "R6"); want(0, T + 16, "R6"); want(1, T + 27, "R6");
    tick(4); nom_seg1 = 9'd3; nom_pre = 10'd2; cfg_ld = 1'b1; tick(1); cfg_ld = 1'b0;
    drain("R6");
    start();
    want(0, T, "R6"); want(1, T + 11, "R6"); want(0, T + 16, "R6");
    drain("R6");
    defaults();

    // R7 lengthen by phase error
    start();
    want(0, T, "R7"); want(1, T + 14, "R7"); want(0, T + 19, "R7"); want(1, T + 30, "R7");
    pulse_edge(T + 3);
    drain("R7");
    // R7 lengthen limited by jump width
    start();
    want(0, T, "R7"); want(1, T + 15, "R7"); want(0, T + 20, "R7");
    pulse_edge(T + 7);
    drain("R7");

    // R9 sync-segment edge ignored, second edge ignored
    start();
    want(0, T, "R9"); want(1, T + 14, "R9"); want(0, T + 19, "R9");
    rx_edge = 1'b1; tick(1); rx_edge = 1'b0;
    pulse_edge(T + 3);
    pulse_edge(T + 5);
    drain("R9");

    // R8 shorten by phase error
    start();
    want(0, T, "R8"); want(1, T + 11, "R8"); want(0, T + 14, "R8"); want(1, T + 25, "R8");
    pulse_edge(T + 13);
    drain("R8");
    // R8 shorten limited by jump width 1
    nom_sjw = 8'd1; load();
    start();
    want(0, T, "R8"); want(1, T + 11, "R8"); want(0, T + 15, "R8"); want(1, T + 26, "R8");
    pulse_edge(T + 13);
    drain("R8");
    defaults();

    // R10 hard sync
    start();
    want(0, T, "R10"); want(0, T + 7, "R10"); want(1, T + 18, "R10"); want(0, T + 23, "R10");
    while (cyc < T + 6) tick(1);
    hard_sync = 1'b1; tick(1); hard_sync = 1'b0;
    drain("R10");

    // R11 switch to data set (pre 2, seg1 3, seg2 2, sjw 1) and back
    dat_pre = 10'd2; dat_seg1 = 9'd3; dat_seg2 = 8'd2; dat_sjw = 8'd1; load();
    phase_sel = 1'b1;
    start();
    want(0, T, "R11"); want(1, T + 11, "R11"); want(0, T + 16, "R11"); want(1, T + 23, "R11");
    want(0, T + 28, "R11"); want(1, T + 35, "R11"); want(0, T + 40, "R11"); want(1, T + 51, "R11");
    want(0, T + 56, "R11");
    while (cyc < T + 15) tick(1);
    check(cur_phase == 1'b0, "R11", cur_phase, 0);
    tick(1);
    check(cur_phase == 1'b1, "R11", cur_phase, 1);
    while (cyc < T + 28) tick(1);
    phase_sel = 1'b0;
    drain("R11");
    // R11 select outside the sample point has no effect
    start();
    want(0, T, "R11"); want(1, T + 11, "R11"); want(0, T + 16, "R11"); want(1, T + 27, "R11");
    tick(2); phase_sel = 1'b1; tick(4); phase_sel = 1'b0;
    drain("R11");
    defaults();

    // R3 nominal ranges
    nom_seg1 = 9'd1;   err_case(1'b1, "R3");
    nom_pre = 10'd0;   err_case(1'b1, "R3");
    nom_pre = 10'd513; err_case(1'b1, "R3");
    nom_sjw = 8'd129;  err_case(1'b1, "R3");
    nom_seg2 = 8'd1;   err_case(1'b1, "R3");
    nom_pre = 10'd512; nom_seg1 = 9'd256; nom_seg2 = 8'd128; nom_sjw = 8'd128; err_case(1'b0, "R3");
    nom_seg1 = 9'd2; nom_seg2 = 8'd2; nom_sjw = 8'd1; err_case(1'b0, "R3");

    // R4 data ranges
    dat_sjw = 8'd17;   err_case(1'b1, "R4");
    dat_seg1 = 9'd33;  err_case(1'b1, "R4");
    dat_seg1 = 9'd0;   err_case(1'b1, "R4");
    dat_seg2 = 8'd17;  err_case(1'b1, "R4");
    dat_pre = 10'd33;  err_case(1'b1, "R4");
    dat_pre = 10'd32; dat_seg1 = 9'd32; dat_seg2 = 8'd16; dat_sjw = 8'd16; err_case(1'b0, "R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule